// File: doc/BRIEF.md
# Sixteen-Function 8-bit ALU

This block is a purely combinational arithmetic logic unit. A 4-bit operation code selects one of sixteen functions. The functions act on two 8-bit operands, `opA` and `opB`. The block returns an 8-bit result, a 16-bit product that is live only for multiplication, and a single carry/borrow flag. The function set has:

- two constant functions: zero fill and all-ones fill;
- add, subtract and multiply;
- increment and decrement of `opA`;
- single-position shifts of `opA`;
- seven bitwise logic functions.

The adder/subtractor is a ripple chain of reversible gate functions and does not use a behavioural `+`. Each bit position holds one two-input Feynman gate, which conditionally inverts the `opB` bit for subtraction. Each bit position also holds two three-input Peres gates, which together form a full adder. Increment and decrement run on the same chain, with a constant one in place of `opB`.

A thin top holds a decoder and a datapath. The decoder turns the opcode into a small struct of strobes. The datapath holds the arithmetic, the shift muxes, the logic unit and the output mux. The block holds no state. Registering the result and fetching the operands are the caller's job.

Top module: `alu16`

## Requirements
- R1: Opcode 4'b0000 drives `result` to 8'h00, and opcode 4'b1111 drives it to 8'hFF, whatever the operands.
- R2: Opcode 4'b0001 gives `result` = (opA + opB) mod 256, and `carry` equal to bit 8 of the 9-bit sum.
- R3: Opcode 4'b0010 gives `result` = (opA - opB) mod 256. In this case `carry` is an active-high borrow that is 1 exactly when opA < opB, taking both as unsigned.
- R4: Opcode 4'b0011 drives `product` to the full 16-bit unsigned opA*opB, and drives `result` to its low byte. For every other opcode, `product` is 16'h0000.
- R5: Opcode 4'b0100 gives opA + 1, wrapping 8'hFF to 8'h00. Opcode 4'b0101 gives opA - 1, wrapping 8'h00 to 8'hFF.
- R6: Opcode 4'b0110 gives {opA[6:0], 1'b0}, and opcode 4'b0111 gives {1'b0, opA[7:1]}. For both, `opB` has no effect on the outputs.
- R7: Opcodes 4'b1000, 4'b1001 and 4'b1011 give the bitwise OR, AND and XOR of opA and opB respectively.
- R8: Opcode 4'b1010 gives ~opA, and `opB` has no effect on the outputs.
- R9: Opcodes 4'b1100, 4'b1101 and 4'b1110 give the bitwise NOR, NAND and XNOR of opA and opB respectively.
- R10: `carry` is 0 for every opcode other than 4'b0001 and 4'b0010, including increment and decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| result | output | 8 | Function result |
| product | output | 16 | Full multiplication product; zero when not multiplying |
| carry | output | 1 | Add carry-out, or subtract borrow; zero otherwise |

## Verification
The bound checker re-evaluates its checks whenever any input changes. It covers the following properties:
- the two constant opcodes;
- the 9-bit sum for add;
- the borrow-versus-magnitude relation for subtract;
- the link between the low product byte and the result;
- the zero product outside multiply;
- the zero carry outside add and subtract;
- the left-shift form.

Some behaviours need a range of operand patterns rather than one relation between ports, so only the bench's scenarios can show them. These are the wrap at the increment and decrement limits, the independence from `opB` of NOT and of the shifts, and the full product at 8'hFF*8'hFF. The bench also compares every opcode against its own reference model, over random operands as well as a fixed vector table.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [2:0] {
    SEL_CONST = 3'd0,
    SEL_ARITH = 3'd1,
    SEL_MUL   = 3'd2,
    SEL_SHL   = 3'd3,
    SEL_SHR   = 3'd4,
    SEL_LOGIC = 3'd5
  } resSel_e;

  typedef enum logic [1:0] {
    LG_OR   = 2'd0,
    LG_AND  = 2'd1,
    LG_XOR  = 2'd2,
    LG_PASS = 2'd3
  } logicOp_e;

  typedef struct packed {
    resSel_e  resSel;
    logic     constOnes;
    logic     subMode;
    logic     bOne;
    logic     carryEn;
    logic     mulEn;
    logicOp_e logicOp;
    logic     logicInv;
  } aluCtrl_t;

endpackage

// File: rtl/alu16_rev_gates.sv
// Reversible primitive functions used by the adder chain.
module alu16_peres (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  assign p = a;
  assign q = a ^ b;
  assign r = (a & b) ^ c;
endmodule

module alu16_feynman (
  input  logic a,
  input  logic b,
  output logic p,
  output logic q
);
  assign p = a;
  assign q = a ^ b;
endmodule

// File: rtl/alu16_addsub.sv
// Ripple adder/subtractor: a Feynman gate conditionally inverts B,
// and two Peres gates per bit form a full adder.
module alu16_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] inA,
  input  logic [WIDTH-1:0] inB,
  input  logic             subMode,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  logic [WIDTH:0]   chain;
  logic [WIDTH-1:0] bMod;
  logic [WIDTH-1:0] halfX;
  logic [WIDTH-1:0] halfG;
  logic [WIDTH-1:0] unusedFeynP;
  logic [WIDTH-1:0] unusedPeresP1;
  logic [WIDTH-1:0] unusedPeresP2;

  assign chain[0] = subMode;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    alu16_feynman u_inv (
      .a(subMode), .b(inB[i]), .p(unusedFeynP[i]), .q(bMod[i])
    );
    // First Peres gate: propagate and generate terms.
    alu16_peres u_half (
      .a(inA[i]), .b(bMod[i]), .c(1'b0),
      .p(unusedPeresP1[i]), .q(halfX[i]), .r(halfG[i])
    );
    // Second Peres gate: sum bit and carry to the next position.
    alu16_peres u_full (
      .a(halfX[i]), .b(chain[i]), .c(halfG[i]),
      .p(unusedPeresP2[i]), .q(sum[i]), .r(chain[i+1])
    );
  end

  assign carryOut = chain[WIDTH];
endmodule

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [3:0] opSel,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl = '{resSel: SEL_CONST, constOnes: 1'b0, subMode: 1'b0, bOne: 1'b0,
             carryEn: 1'b0, mulEn: 1'b0, logicOp: LG_OR, logicInv: 1'b0};
    unique case (opSel)
      4'b0000: ctrl.resSel = SEL_CONST;
      4'b0001: begin ctrl.resSel = SEL_ARITH; ctrl.carryEn = 1'b1; end
      4'b0010: begin ctrl.resSel = SEL_ARITH; ctrl.carryEn = 1'b1; ctrl.subMode = 1'b1; end
      4'b0011: begin ctrl.resSel = SEL_MUL; ctrl.mulEn = 1'b1; end
      4'b0100: begin ctrl.resSel = SEL_ARITH; ctrl.bOne = 1'b1; end
      4'b0101: begin ctrl.resSel = SEL_ARITH; ctrl.bOne = 1'b1; ctrl.subMode = 1'b1; end
      4'b0110: ctrl.resSel = SEL_SHL;
      4'b0111: ctrl.resSel = SEL_SHR;
      4'b1000: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_OR; end
      4'b1001: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_AND; end
      4'b1010: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_PASS; ctrl.logicInv = 1'b1; end
      4'b1011: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_XOR; end
      4'b1100: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_OR; ctrl.logicInv = 1'b1; end
      4'b1101: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_AND; ctrl.logicInv = 1'b1; end
      4'b1110: begin ctrl.resSel = SEL_LOGIC; ctrl.logicOp = LG_XOR; ctrl.logicInv = 1'b1; end
      4'b1111: begin ctrl.resSel = SEL_CONST; ctrl.constOnes = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_dp.sv
module alu16_dp
  import alu16_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluCtrl_t           ctrl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [WIDTH-1:0]   result,
  output logic [2*WIDTH-1:0] product,
  output logic               carry
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] arithB;
  logic [WIDTH-1:0] arithSum;
  logic             arithCout;
  logic [WIDTH-1:0] shlVal;
  logic [WIDTH-1:0] shrVal;
  logic [WIDTH-1:0] logicRaw;
  logic [WIDTH-1:0] logicVal;
  logic [PW-1:0]    mulFull;

  assign arithB = ctrl.bOne ? WIDTH'(1) : opB;

  alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
    .inA(opA), .inB(arithB), .subMode(ctrl.subMode),
    .sum(arithSum), .carryOut(arithCout)
  );

  assign mulFull = ctrl.mulEn ? (PW'(opA) * PW'(opB)) : '0;
  assign product = mulFull;

  // Shift multiplexers: one position, vacated bit filled with zero.
  assign shlVal = {opA[WIDTH-2:0], 1'b0};
  assign shrVal = {1'b0, opA[WIDTH-1:1]};

  always_comb begin
    unique case (ctrl.logicOp)
      LG_OR:   logicRaw = opA | opB;
      LG_AND:  logicRaw = opA & opB;
      LG_XOR:  logicRaw = opA ^ opB;
      default: logicRaw = opA;
    endcase
  end
  assign logicVal = ctrl.logicInv ? ~logicRaw : logicRaw;

  always_comb begin
    unique case (ctrl.resSel)
      SEL_CONST: result = ctrl.constOnes ? '1 : '0;
      SEL_ARITH: result = arithSum;
      SEL_MUL:   result = mulFull[WIDTH-1:0];
      SEL_SHL:   result = shlVal;
      SEL_SHR:   result = shrVal;
      SEL_LOGIC: result = logicVal;
      default:   result = '0;
    endcase
  end

  // A subtract completes with no carry-out exactly when a borrow occurred.
  assign carry = ctrl.carryEn & (arithCout ^ ctrl.subMode);
endmodule

// File: rtl/alu16.sv
module alu16
  import alu16_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [3:0]         opSel,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [WIDTH-1:0]   result,
  output logic [2*WIDTH-1:0] product,
  output logic               carry
);
  aluCtrl_t ctrl;

  alu16_ctrl u_ctrl (
    .opSel(opSel), .ctrl(ctrl)
  );

  alu16_dp #(.WIDTH(WIDTH)) u_dp (
    .ctrl(ctrl), .opA(opA), .opB(opB),
    .result(result), .product(product), .carry(carry)
  );
endmodule

// File: rtl/alu16_checker.sv
module alu16_checker #(
  parameter int WIDTH = 8
) (
  input logic [3:0]         opSel,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [WIDTH-1:0]   result,
  input logic [2*WIDTH-1:0] product,
  input logic               carry
);
  always_comb begin
    if (opSel == 4'b0000) a_r1_clear: assert (result == '0);
    if (opSel == 4'b1111) a_r1_preset: assert (result == '1);
    if (opSel == 4'b0001) a_r2_add_sum: assert ({carry, result} == ({1'b0, opA} + {1'b0, opB}));
    if (opSel == 4'b0010) a_r3_borrow: assert (carry == (opA < opB));
    if (opSel == 4'b0011) a_r4_low_byte: assert (result == product[WIDTH-1:0]);
    if (opSel != 4'b0011) a_r4_product_idle: assert (product == '0);
    if (opSel != 4'b0001 && opSel != 4'b0010) a_r10_carry_idle: assert (!carry);
    if (opSel == 4'b0110) a_r6_shift_left: assert (result == {opA[WIDTH-2:0], 1'b0});
  end
endmodule

bind alu16 alu16_checker #(.WIDTH(WIDTH)) u_alu16_checker (
  .opSel(opSel), .opA(opA), .opB(opB),
  .result(result), .product(product), .carry(carry)
);

// File: tb/alu16_bench.sv
module alu16_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opSel = 4'h0;
  logic [7:0] opA = 8'h00;
  logic [7:0] opB = 8'h00;
  logic [7:0] result;
  logic [15:0] product;
  logic       carry;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu16 #(.WIDTH(8)) u_alu16 (
    .opSel(opSel), .opA(opA), .opB(opB),
    .result(result), .product(product), .carry(carry)
  );

  // {opcode, A, B, expected result, expected carry}
  localparam int NV = 20;
  localparam logic [28:0] VEC [NV] = '{
    {4'h0, 8'hAA, 8'h55, 8'h00, 1'b0},
    {4'h1, 8'hFF, 8'h01, 8'h00, 1'b1},
    {4'h1, 8'h7F, 8'h01, 8'h80, 1'b0},
    {4'h2, 8'h05, 8'h07, 8'hFE, 1'b1},
    {4'h2, 8'h07, 8'h05, 8'h02, 1'b0},
    {4'h2, 8'h00, 8'h00, 8'h00, 1'b0},
    {4'h3, 8'h10, 8'h10, 8'h00, 1'b0},
    {4'h3, 8'h0F, 8'h03, 8'h2D, 1'b0},
    {4'h4, 8'hFF, 8'h00, 8'h00, 1'b0},
    {4'h5, 8'h00, 8'h33, 8'hFF, 1'b0},
    {4'h6, 8'h81, 8'hFF, 8'h02, 1'b0},
    {4'h7, 8'h81, 8'hFF, 8'h40, 1'b0},
    {4'h8, 8'hF0, 8'h0F, 8'hFF, 1'b0},
    {4'h9, 8'hF0, 8'h3C, 8'h30, 1'b0},
    {4'hA, 8'h5A, 8'hFF, 8'hA5, 1'b0},
    {4'hB, 8'hFF, 8'h0F, 8'hF0, 1'b0},
    {4'hC, 8'hF0, 8'h0F, 8'h00, 1'b0},
    {4'hD, 8'hF0, 8'h3C, 8'hCF, 1'b0},
    {4'hE, 8'hF0, 8'h3C, 8'h33, 1'b0},
    {4'hF, 8'h00, 8'h00, 8'hFF, 1'b0}
  };

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h0, 4'hF:       return "R1";
      4'h1:             return "R2";
      4'h2:             return "R3";
      4'h3:             return "R4";
      4'h4, 4'h5:       return "R5";
      4'h6, 4'h7:       return "R6";
      4'h8, 4'h9, 4'hB: return "R7";
      4'hA:             return "R8";
      default:          return "R9";
    endcase
  endfunction

  // Behavioural reference: {carry, product, result}
  function automatic logic [24:0] refModel(input logic [3:0] op,
                                           input logic [7:0] a, input logic [7:0] b);
    logic [8:0]  s;
    logic [15:0] p;
    logic [7:0]  r;
    logic        c;
    p = 16'h0; c = 1'b0; r = 8'h00;
    case (op)
      4'h0: r = 8'h00;
      4'h1: begin s = {1'b0, a} + {1'b0, b}; r = s[7:0]; c = s[8]; end
      4'h2: begin r = a - b; c = (a < b); end
      4'h3: begin p = {8'h00, a} * {8'h00, b}; r = p[7:0]; end
      4'h4: r = a + 8'd1;
      4'h5: r = a - 8'd1;
      4'h6: r = a << 1;
      4'h7: r = a >> 1;
      4'h8: r = a | b;
      4'h9: r = a & b;
      4'hA: r = ~a;
      4'hB: r = a ^ b;
      4'hC: r = ~(a | b);
      4'hD: r = ~(a & b);
      4'hE: r = ~(a ^ b);
      default: r = 8'hFF;
    endcase
    return {c, p, r};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    @(posedge clk);
    #1;
  endtask

  task automatic fullCompare(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [24:0] e;
    apply(op, a, b);
    e = refModel(op, a, b);
    check(reqOf(op), "result", {8'h00, result}, {8'h00, e[7:0]});
    check("R4", "product", product, e[23:8]);
    check((op == 4'h1 || op == 4'h2) ? reqOf(op) : "R10", "carry",
          {15'h0, carry}, {15'h0, e[24]});
  endtask

  initial begin
    logic [7:0] keepRes;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Reset state: all-zero inputs select clear with no product or carry (R1, R4, R10).
    apply(4'h0, 8'h00, 8'h00);
    check("R1", "reset result", {8'h00, result}, 16'h0000);
    check("R4", "reset product", product, 16'h0000);
    check("R10", "reset carry", {15'h0, carry}, 16'h0000);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][28:25], VEC[i][24:17], VEC[i][16:9]);
      check(reqOf(VEC[i][28:25]), "vector result", {8'h00, result}, {8'h00, VEC[i][8:1]});
      check((VEC[i][28:25] == 4'h1 || VEC[i][28:25] == 4'h2) ? reqOf(VEC[i][28:25]) : "R10",
            "vector carry", {15'h0, carry}, {15'h0, VEC[i][0]});
    end

    // Random operands against the reference, every opcode
    for (int op = 0; op < 16; op++) begin
      for (int n = 0; n < 40; n++) begin
        fullCompare(4'(op), 8'($urandom), 8'($urandom));
      end
    end

    // Corner cases
    apply(4'h3, 8'hFF, 8'hFF);
    check("R4", "max product", product, 16'hFE01);
    check("R4", "max product low byte", {8'h00, result}, 16'h0001);
    apply(4'h1, 8'hFF, 8'hFF);
    check("R4", "product idle on add", product, 16'h0000);
    check("R2", "FF+FF carry", {15'h0, carry}, 16'h0001);
    apply(4'h4, 8'hFF, 8'h00);
    check("R5", "increment wrap", {8'h00, result}, 16'h0000);
    check("R10", "increment no carry", {15'h0, carry}, 16'h0000);
    apply(4'h5, 8'h00, 8'h00);
    check("R5", "decrement wrap", {8'h00, result}, 16'h00FF);
    check("R10", "decrement no carry", {15'h0, carry}, 16'h0000);
    apply(4'h2, 8'h00, 8'h01);
    check("R3", "borrow at zero", {7'h0, carry, result}, 16'h01FF);

    // R8: NOT ignores B
    apply(4'hA, 8'h3C, 8'h00);
    keepRes = result;
    apply(4'hA, 8'h3C, 8'hFF);
    check("R8", "NOT independent of B", {8'h00, result}, {8'h00, keepRes});
    check("R8", "NOT value", {8'h00, result}, 16'h00C3);

    // R6: shifts ignore B
    apply(4'h7, 8'h01, 8'h00);
    check("R6", "right shift drops LSB", {8'h00, result}, 16'h0000);
    apply(4'h7, 8'h01, 8'hFF);
    check("R6", "right shift with B ones", {8'h00, result}, 16'h0000);
    apply(4'h6, 8'h80, 8'h5A);
    check("R6", "left shift drops MSB", {8'h00, result}, 16'h0000);

    // R1: preset independent of operands
    apply(4'hF, 8'h12, 8'h34);
    check("R1", "preset with operands", {8'h00, result}, 16'h00FF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule